// File: doc/BRIEF.md
# Zero-Run Auto Mute Controller

This block sets the effective mute state of a stereo output path. A two-bit mute control selects one of three policies: mute off, automatic mute, or forced mute. A one-cycle frame strobe carries one left and one right sample. The block counts how many frames in a row had both samples at zero. In automatic mode, the output path mutes once that run reaches a threshold. It unmutes as soon as a frame carries any nonzero sample.

The block does not switch the output abruptly. Instead it moves a gain code one step per frame, towards zero when muted and towards unity when not, so every mute and unmute is a linear fade. A status flag reports the automatic-mute state while the block is in automatic mode, so that external logic can see or override it. Wired-OR pin electrics and analogue stages stay outside this block.

Top module: `zmute_ctrl`

## Requirements
- R1: The mute control is decoded as 2'b00 = off, 2'b01 = automatic, and 2'b1x = forced on. `mute_act` gives the effective mute decision combinationally from the current control and the registered zero-run state.
- R2: A frame counts as zero when `frm_vld` is high and both `smp_l` and `smp_r` are zero. After the ZRUN-th (default 64) consecutive zero frame, the run is detected from the next clock edge on. Before that frame it is not detected.
- R3: A frame with a nonzero sample on either channel resets the run count. The detected state drops from the clock edge that takes that frame.
- R4: The run count saturates at ZRUN and does not wrap, so detection holds through any number of further zero frames.
- R5: With control 2'b00, neither `mute_act` nor `auto_sts` is ever set, whatever the zero run.
- R6: With control 2'b1x, `mute_act` is high regardless of the sample data.
- R7: `auto_sts` is high exactly when the control is 2'b01 and the zero run is detected.
- R8: On each frame, `gain` steps down by one when `mute_act` is high and up by one when it is low. It saturates at 0 and at RAMP (default 16, unity).
- R9: Reset sets `gain` to 0 and clears the run count.
- R10: Cycles with `frm_vld` low change neither `gain` nor the run count, whatever the sample inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mute_ctl | input | 2 | Mute policy: 00 off, 01 automatic, 1x forced |
| frm_vld | input | 1 | One-cycle strobe marking a stereo frame |
| smp_l | input | DW | Left sample of the frame |
| smp_r | input | DW | Right sample of the frame |
| gain | output | $clog2(RAMP+1) | Linear gain code, 0 = silent, RAMP = unity |
| mute_act | output | 1 | Effective mute decision |
| auto_sts | output | 1 | Automatic-mute status, high only in automatic mode |

## Verification
The run count and `gain` update on the clock edge that takes a frame strobe. Run detection is therefore visible one cycle after the threshold frame, and the gain step lags a policy change by one frame. `mute_act` and `auto_sts` follow a change of `mute_ctl` within the same cycle. The bench drives inputs on falling edges and drops the strobe after one cycle. It samples outputs only on a later falling edge, after every register on the path has taken its edge. Expected gains are worked out frame by frame from the policy that was in force when each frame arrived.

// File: rtl/zmute_ctrl.sv
module zmute_ctrl #(
  parameter int DW   = 18,
  parameter int ZRUN = 64,
  parameter int RAMP = 16,
  localparam int CW  = $clog2(ZRUN + 1),
  localparam int GW  = $clog2(RAMP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mute_ctl,
  input  logic          frm_vld,
  input  logic [DW-1:0] smp_l,
  input  logic [DW-1:0] smp_r,
  output logic [GW-1:0] gain,
  output logic          mute_act,
  output logic          auto_sts
);

  logic [CW-1:0] zcnt;
  logic          run_hit;
  logic          zero_frm;

  assign zero_frm = (smp_l == '0) && (smp_r == '0);
  assign run_hit  = (zcnt == CW'(ZRUN));
  assign auto_sts = (mute_ctl == 2'b01) && run_hit;
  assign mute_act = mute_ctl[1] || auto_sts;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zcnt <= '0;
    end else if (frm_vld) begin
      if (!zero_frm)     zcnt <= '0;
      else if (!run_hit) zcnt <= zcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain <= '0;
    end else if (frm_vld) begin
      if (mute_act) begin
        if (gain != '0) gain <= gain - 1'b1;
      end else if (gain != GW'(RAMP)) begin
        gain <= gain + 1'b1;
      end
    end
  end

endmodule

module zmute_ctrl_chk #(
  parameter int DW   = 18,
  parameter int RAMP = 16,
  parameter int GW   = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mute_ctl,
  input logic          frm_vld,
  input logic [DW-1:0] smp_l,
  input logic [DW-1:0] smp_r,
  input logic [GW-1:0] gain,
  input logic          mute_act,
  input logic          auto_sts
);

  AST_GAIN_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    gain <= GW'(RAMP)); // R8

  AST_GAIN_ONLY_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_vld |=> $stable(gain)); // R10

  AST_FORCED_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    mute_ctl[1] |-> mute_act); // R6

  AST_OFF_NO_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_ctl == 2'b00) |-> (!mute_act && !auto_sts)); // R5

  AST_NONZERO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && (smp_l != '0 || smp_r != '0)) |=> !auto_sts); // R3

  AST_STS_AUTO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    auto_sts |-> (mute_ctl == 2'b01)); // R7

endmodule

bind zmute_ctrl zmute_ctrl_chk #(.DW(DW), .RAMP(RAMP), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mute_ctl(mute_ctl), .frm_vld(frm_vld),
  .smp_l(smp_l), .smp_r(smp_r), .gain(gain), .mute_act(mute_act),
  .auto_sts(auto_sts)
);

// File: tb/tb_zmute_ctrl.sv
module tb_zmute_ctrl;
  localparam int DW = 18;
  localparam int GW = 5;
  localparam int NSEG = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mute_ctl = 2'b00;
  logic frm_vld = 1'b0;
  logic [DW-1:0] smp_l = '0, smp_r = '0;
  logic [GW-1:0] gain;
  logic mute_act, auto_sts;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  zmute_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mute_ctl(mute_ctl), .frm_vld(frm_vld),
    .smp_l(smp_l), .smp_r(smp_r), .gain(gain), .mute_act(mute_act),
    .auto_sts(auto_sts)
  );

  // {mode, frames, left, right, exp_gain, exp_auto_sts, exp_mute_act}
  localparam logic [32:0] TBL [NSEG] = '{
    {2'b00, 8'd10,  8'd5, 8'd0, 5'd10, 1'b0, 1'b0},
    {2'b00, 8'd10,  8'd5, 8'd0, 5'd16, 1'b0, 1'b0},
    {2'b10, 8'd4,   8'd5, 8'd0, 5'd12, 1'b0, 1'b1},
    {2'b11, 8'd20,  8'd5, 8'd0, 5'd0,  1'b0, 1'b1},
    {2'b00, 8'd16,  8'd0, 8'd0, 5'd16, 1'b0, 1'b0},
    {2'b01, 8'd47,  8'd0, 8'd0, 5'd16, 1'b0, 1'b0},
    {2'b01, 8'd1,   8'd0, 8'd0, 5'd16, 1'b1, 1'b1},
    {2'b01, 8'd5,   8'd0, 8'd0, 5'd11, 1'b1, 1'b1},
    {2'b00, 8'd1,   8'd0, 8'd0, 5'd12, 1'b0, 1'b0},
    {2'b01, 8'd100, 8'd0, 8'd0, 5'd0,  1'b1, 1'b1},
    {2'b01, 8'd1,   8'd0, 8'd3, 5'd0,  1'b0, 1'b0},
    {2'b01, 8'd3,   8'd5, 8'd0, 5'd3,  1'b0, 1'b0},
    {2'b01, 8'd63,  8'd0, 8'd0, 5'd16, 1'b0, 1'b0},
    {2'b01, 8'd1,   8'd7, 8'd0, 5'd16, 1'b0, 1'b0},
    {2'b01, 8'd64,  8'd0, 8'd0, 5'd16, 1'b1, 1'b1},
    {2'b10, 8'd2,   8'd0, 8'd0, 5'd14, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic frames(input int n, input logic [DW-1:0] l, input logic [DW-1:0] r);
    for (int i = 0; i < n; i++) begin
      smp_l = l; smp_r = r; frm_vld = 1'b1;
      @(negedge clk);
      frm_vld = 1'b0; smp_l = '0; smp_r = '0;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset gain", gain, 0);
    chk("R9 reset mute_act", mute_act, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int s = 0; s < NSEG; s++) begin
      mute_ctl = TBL[s][32:31];
      frames(int'(TBL[s][30:23]), DW'(TBL[s][22:15]), DW'(TBL[s][14:7]));
      chk($sformatf("R1 R2 R3 R4 R6 R8 seg%0d gain", s), gain, int'(TBL[s][6:2]));
      chk($sformatf("R2 R5 R7 seg%0d auto_sts", s), auto_sts, int'(TBL[s][1]));
      chk($sformatf("R1 R5 R6 seg%0d mute_act", s), mute_act, int'(TBL[s][0]));
    end

    // R7: switching to automatic mode exposes the saturated run at once
    mute_ctl = 2'b01;
    #0;
    @(negedge clk);
    chk("R7 auto_sts after mode switch", auto_sts, 1);
    // R10: nonzero samples without a strobe are ignored
    smp_l = 18'd9; smp_r = 18'd9;
    repeat (5) @(negedge clk);
    chk("R10 no strobe keeps run", auto_sts, 1);
    chk("R10 no strobe keeps gain", gain, 14);
    smp_l = '0; smp_r = '0;

    // R9: reset mid-run clears count and gain
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 mid reset gain", gain, 0);
    chk("R9 mid reset auto_sts", auto_sts, 0);
    rst_n = 1'b1;
    @(negedge clk);
    frames(63, '0, '0);
    chk("R2 R9 63 zeros after reset", auto_sts, 0);
    frames(1, '0, '0);
    chk("R2 64th zero frame", auto_sts, 1);
    chk("R8 gain capped during run", gain, 16);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule